// File: doc/BRIEF.md
# Audio Control and I/O Address Decoder

This block sits on the 8-bit I/O bus of a console I/O chip. It compares every write and read address against all eight address bits; partial-decode mirrors do not exist. Two write addresses are passed on to an on-board FM synthesis unit as register-select and register-data strobes. A third address holds a two-bit audio control value. That value decides which of the two sound sources, the PSG and the FM unit, may reach the audio output.

On the read side, the block returns the audio control value with its unused bits cleared. Four address slots expose the two controller-port data bytes, and only while the I/O-disable input is low. Any other read sees an open bus.

Top module: `audio_io_decoder`

## Requirements
- R1: A write strobe fires only for an exact 8-bit match. No address other than 0xF0 ever pulses `fm_addr_wr`, no address other than 0xF1 pulses `fm_data_wr`, and no address other than 0xF2 changes the audio control value.
- R2: A write to 0xF0 with `io_wr` high makes `fm_addr_wr` high for exactly one cycle, starting one clock edge later. During that cycle `fm_wdata` carries the written byte.
- R3: A write to 0xF1 with `io_wr` high makes `fm_data_wr` high for exactly one cycle, starting one clock edge later. During that cycle `fm_wdata` carries the written byte.
- R4: A write to 0xF2 stores data bits 1..0 as the mode. The bits are decoded as follows, and the outputs follow one edge after the write:
  - mode 00 gives `psg_en`=1, `fm_en`=0.
  - mode 01 gives `psg_en`=0, `fm_en`=1.
  - mode 10 gives both 0.
  - mode 11 gives both 1.
- R5: After synchronous reset the mode is 00. That means `psg_en`=1, `fm_en`=0, and both strobes are low.
- R6: A read of 0xF2 returns the mode in bits 1..0 and zeros in bits 7..2, whatever upper data bits were written.
- R7: With `io_disable` low, reads of 0xC0 and 0xDC return `port_a_data`, and reads of 0xC1 and 0xDD return `port_b_data`. Address bit 0 picks the port. With `io_disable` high, these four addresses return 0xFF.
- R8: A read of any other address returns 0xFF. This includes 0xF0 and 0xF1.
- R9: With `io_wr` low, no strobe fires and the mode is kept, even when the address is 0xF0, 0xF1 or 0xF2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_wr | input | 1 | I/O write enable for the current cycle |
| io_addr | input | 8 | I/O address |
| io_wdata | input | 8 | I/O write data |
| io_disable | input | 1 | I/O-disable bit of the memory control setting; high blocks controller reads |
| port_a_data | input | 8 | Controller data for the even port address |
| port_b_data | input | 8 | Controller data for the odd port address |
| fm_addr_wr | output | 1 | One-cycle FM register-select write strobe |
| fm_data_wr | output | 1 | One-cycle FM register-data write strobe |
| fm_wdata | output | 8 | Byte accompanying the FM strobes |
| psg_en | output | 1 | PSG output enable |
| fm_en | output | 1 | FM output enable |
| rd_data | output | 8 | Read data for the current address |

## Verification
The FM strobes, `fm_wdata`, `psg_en` and `fm_en` are registered, so each is due one rising edge after the cycle in which the write is presented. The strobes must drop again after the next edge. `rd_data` is combinational from the address, the mode, `io_disable` and the port inputs, so it is valid in the same cycle.

The bench changes inputs on the falling edge. It checks registered results at the following falling edge, which is the first one after the capturing rising edge. It checks read data one nanosecond after the address settles, well before any rising edge. Every address is swept for both writes and reads, with both values of `io_disable`.

// File: rtl/audio_dec_pkg.sv
package audio_dec_pkg;

    localparam int IO_ADDR_W = 8;
    localparam int IO_DATA_W = 8;
    localparam int MODE_W    = 2;

    localparam logic [MODE_W-1:0] MODE_RESET = 2'b00;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_FM_ADDR,
        SEL_FM_DATA,
        SEL_AUDIO,
        SEL_PAD
    } addr_sel_e;

    typedef struct packed {
        logic psg_on;
        logic fm_on;
    } out_en_t;

    typedef struct packed {
        logic                 addr_wr;
        logic                 data_wr;
        logic [IO_DATA_W-1:0] wdata;
    } fm_req_t;

    // PSG is live when bit 1 of (mode + 1) is clear; FM follows bit 0.
    function automatic out_en_t mode_to_enables(input logic [MODE_W-1:0] mode);
        out_en_t          r;
        logic [MODE_W-1:0] inc;
        inc      = mode + MODE_W'(1);
        r.psg_on = ~inc[1];
        r.fm_on  = mode[0];
        return r;
    endfunction

endpackage

// File: rtl/io_addr_decode.sv
module io_addr_decode
    import audio_dec_pkg::*;
#(
    parameter logic [IO_ADDR_W-1:0] FM_ADDR_PORT = 8'hF0,
    parameter logic [IO_ADDR_W-1:0] FM_DATA_PORT = 8'hF1,
    parameter logic [IO_ADDR_W-1:0] AUDIO_PORT   = 8'hF2,
    parameter logic [IO_ADDR_W-1:0] PAD_PAIR_LO  = 8'hC0,
    parameter logic [IO_ADDR_W-1:0] PAD_PAIR_HI  = 8'hDC
) (
    input  logic [IO_ADDR_W-1:0] addr,
    output addr_sel_e            sel,
    output logic                 pad_odd
);
    logic pad_hit;

    // Pad pairs match on bits 7..1; bit 0 picks the port inside a pair.
    assign pad_hit = (addr[IO_ADDR_W-1:1] == PAD_PAIR_LO[IO_ADDR_W-1:1]) ||
                     (addr[IO_ADDR_W-1:1] == PAD_PAIR_HI[IO_ADDR_W-1:1]);
    assign pad_odd = addr[0];

    always_comb begin
        if (addr == FM_ADDR_PORT)      sel = SEL_FM_ADDR;
        else if (addr == FM_DATA_PORT) sel = SEL_FM_DATA;
        else if (addr == AUDIO_PORT)   sel = SEL_AUDIO;
        else if (pad_hit)              sel = SEL_PAD;
        else                           sel = SEL_NONE;
    end
endmodule

// File: rtl/audio_ctrl_reg.sv
module audio_ctrl_reg
    import audio_dec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [MODE_W-1:0] wmode,
    output logic [MODE_W-1:0] mode,
    output out_en_t           en
);
    logic [MODE_W-1:0] mode_q;

    always_ff @(posedge clk) begin
        if (rst)       mode_q <= MODE_RESET;
        else if (load) mode_q <= wmode;
    end

    assign mode = mode_q;
    assign en   = mode_to_enables(mode_q);
endmodule

// File: rtl/fm_write_gen.sv
module fm_write_gen
    import audio_dec_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 io_wr,
    input  addr_sel_e            sel,
    input  logic [IO_DATA_W-1:0] wdata,
    output fm_req_t              req
);
    fm_req_t req_q;
    logic    hit_addr;
    logic    hit_data;

    assign hit_addr = io_wr && (sel == SEL_FM_ADDR);
    assign hit_data = io_wr && (sel == SEL_FM_DATA);

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= '0;
        end else begin
            req_q.addr_wr <= hit_addr;
            req_q.data_wr <= hit_data;
            if (hit_addr || hit_data) req_q.wdata <= wdata;
        end
    end

    assign req = req_q;
endmodule

// File: rtl/io_read_mux.sv
module io_read_mux
    import audio_dec_pkg::*;
(
    input  addr_sel_e            sel,
    input  logic                 pad_odd,
    input  logic                 io_disable,
    input  logic [MODE_W-1:0]    mode,
    input  logic [IO_DATA_W-1:0] pad_a,
    input  logic [IO_DATA_W-1:0] pad_b,
    output logic [IO_DATA_W-1:0] rdata
);
    logic [IO_DATA_W-1:0] ctrl_word;

    // Control readback: mode in the low bits, every other bit zero.
    genvar gi;
    generate
        for (gi = 0; gi < IO_DATA_W; gi++) begin : g_ctrl_bits
            if (gi < MODE_W) begin : g_mode
                assign ctrl_word[gi] = mode[gi];
            end else begin : g_zero
                assign ctrl_word[gi] = 1'b0;
            end
        end
    endgenerate

    always_comb begin
        rdata = '1;
        case (sel)
            SEL_AUDIO: rdata = ctrl_word;
            SEL_PAD:   if (!io_disable) rdata = pad_odd ? pad_b : pad_a;
            default:   rdata = '1;
        endcase
    end
endmodule

// File: rtl/audio_io_decoder.sv
module audio_io_decoder
    import audio_dec_pkg::*;
#(
    parameter logic [IO_ADDR_W-1:0] FM_ADDR_PORT = 8'hF0,
    parameter logic [IO_ADDR_W-1:0] FM_DATA_PORT = 8'hF1,
    parameter logic [IO_ADDR_W-1:0] AUDIO_PORT   = 8'hF2,
    parameter logic [IO_ADDR_W-1:0] PAD_PAIR_LO  = 8'hC0,
    parameter logic [IO_ADDR_W-1:0] PAD_PAIR_HI  = 8'hDC
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 io_wr,
    input  logic [IO_ADDR_W-1:0] io_addr,
    input  logic [IO_DATA_W-1:0] io_wdata,
    input  logic                 io_disable,
    input  logic [IO_DATA_W-1:0] port_a_data,
    input  logic [IO_DATA_W-1:0] port_b_data,
    output logic                 fm_addr_wr,
    output logic                 fm_data_wr,
    output logic [IO_DATA_W-1:0] fm_wdata,
    output logic                 psg_en,
    output logic                 fm_en,
    output logic [IO_DATA_W-1:0] rd_data
);
    addr_sel_e         sel;
    logic              pad_odd;
    logic [MODE_W-1:0] mode;
    out_en_t           en;
    fm_req_t           req;

    io_addr_decode #(
        .FM_ADDR_PORT(FM_ADDR_PORT),
        .FM_DATA_PORT(FM_DATA_PORT),
        .AUDIO_PORT  (AUDIO_PORT),
        .PAD_PAIR_LO (PAD_PAIR_LO),
        .PAD_PAIR_HI (PAD_PAIR_HI)
    ) dec_i (
        .addr   (io_addr),
        .sel    (sel),
        .pad_odd(pad_odd)
    );

    audio_ctrl_reg ctrl_i (
        .clk  (clk),
        .rst  (rst),
        .load (io_wr && (sel == SEL_AUDIO)),
        .wmode(io_wdata[MODE_W-1:0]),
        .mode (mode),
        .en   (en)
    );

    fm_write_gen fmw_i (
        .clk  (clk),
        .rst  (rst),
        .io_wr(io_wr),
        .sel  (sel),
        .wdata(io_wdata),
        .req  (req)
    );

    io_read_mux rmux_i (
        .sel       (sel),
        .pad_odd   (pad_odd),
        .io_disable(io_disable),
        .mode      (mode),
        .pad_a     (port_a_data),
        .pad_b     (port_b_data),
        .rdata     (rd_data)
    );

    assign fm_addr_wr = req.addr_wr;
    assign fm_data_wr = req.data_wr;
    assign fm_wdata   = req.wdata;
    assign psg_en     = en.psg_on;
    assign fm_en      = en.fm_on;
endmodule

// File: rtl/audio_io_decoder_chk.sv
module audio_io_decoder_chk
    import audio_dec_pkg::*;
#(
    parameter logic [IO_ADDR_W-1:0] FM_ADDR_PORT = 8'hF0,
    parameter logic [IO_ADDR_W-1:0] FM_DATA_PORT = 8'hF1,
    parameter logic [IO_ADDR_W-1:0] AUDIO_PORT   = 8'hF2,
    parameter logic [IO_ADDR_W-1:0] PAD_PAIR_LO  = 8'hC0,
    parameter logic [IO_ADDR_W-1:0] PAD_PAIR_HI  = 8'hDC
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 io_wr,
    input logic [IO_ADDR_W-1:0] io_addr,
    input logic [IO_DATA_W-1:0] io_wdata,
    input logic                 io_disable,
    input logic                 fm_addr_wr,
    input logic                 fm_data_wr,
    input logic [IO_DATA_W-1:0] fm_wdata,
    input logic                 psg_en,
    input logic                 fm_en,
    input logic [IO_DATA_W-1:0] rd_data
);
    p_addr_strobe_src_r2: assert property (@(posedge clk) disable iff (rst)
        fm_addr_wr |-> ($past(io_wr) && ($past(io_addr) == FM_ADDR_PORT)));

    p_addr_strobe_data_r2: assert property (@(posedge clk) disable iff (rst)
        fm_addr_wr |-> (fm_wdata == $past(io_wdata)));

    p_data_strobe_src_r3: assert property (@(posedge clk) disable iff (rst)
        fm_data_wr |-> ($past(io_wr) && ($past(io_addr) == FM_DATA_PORT)));

    p_data_strobe_data_r3: assert property (@(posedge clk) disable iff (rst)
        fm_data_wr |-> (fm_wdata == $past(io_wdata)));

    p_strobe_exclusive_r1: assert property (@(posedge clk) disable iff (rst)
        !(fm_addr_wr && fm_data_wr));

    p_reset_state_r5: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (psg_en && !fm_en && !fm_addr_wr && !fm_data_wr));

    p_mode_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !($past(io_wr) && ($past(io_addr) == AUDIO_PORT)) |-> ($stable(psg_en) && $stable(fm_en)));

    p_ctrl_upper_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (io_addr == AUDIO_PORT) |-> (rd_data[IO_DATA_W-1:MODE_W] == '0));

    p_pad_gate_r7: assert property (@(posedge clk) disable iff (rst)
        (io_disable && ((io_addr[IO_ADDR_W-1:1] == PAD_PAIR_LO[IO_ADDR_W-1:1]) ||
                        (io_addr[IO_ADDR_W-1:1] == PAD_PAIR_HI[IO_ADDR_W-1:1])))
        |-> (rd_data == '1));
endmodule

bind audio_io_decoder audio_io_decoder_chk #(
    .FM_ADDR_PORT(FM_ADDR_PORT),
    .FM_DATA_PORT(FM_DATA_PORT),
    .AUDIO_PORT  (AUDIO_PORT),
    .PAD_PAIR_LO (PAD_PAIR_LO),
    .PAD_PAIR_HI (PAD_PAIR_HI)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .io_wr     (io_wr),
    .io_addr   (io_addr),
    .io_wdata  (io_wdata),
    .io_disable(io_disable),
    .fm_addr_wr(fm_addr_wr),
    .fm_data_wr(fm_data_wr),
    .fm_wdata  (fm_wdata),
    .psg_en    (psg_en),
    .fm_en     (fm_en),
    .rd_data   (rd_data)
);

// File: tb/audio_io_decoder_tb_top.sv
`timescale 1ns/1ps
module audio_io_decoder_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       io_wr = 1'b0;
    logic [7:0] io_addr = 8'h00;
    logic [7:0] io_wdata = 8'h00;
    logic       io_disable = 1'b0;
    logic [7:0] port_a_data = 8'h00;
    logic [7:0] port_b_data = 8'h00;
    logic       fm_addr_wr;
    logic       fm_data_wr;
    logic [7:0] fm_wdata;
    logic       psg_en;
    logic       fm_en;
    logic [7:0] rd_data;

    int checks = 0;
    int errors = 0;
    logic [1:0] exp_mode = 2'b00;

    always #2 clk = ~clk;

    audio_io_decoder dut_i (
        .clk        (clk),
        .rst        (rst),
        .io_wr      (io_wr),
        .io_addr    (io_addr),
        .io_wdata   (io_wdata),
        .io_disable (io_disable),
        .port_a_data(port_a_data),
        .port_b_data(port_b_data),
        .fm_addr_wr (fm_addr_wr),
        .fm_data_wr (fm_data_wr),
        .fm_wdata   (fm_wdata),
        .psg_en     (psg_en),
        .fm_en      (fm_en),
        .rd_data    (rd_data)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [1:0] enables_of(input logic [1:0] m);
        return {(m == 2'b00) || (m == 2'b11), (m == 2'b01) || (m == 2'b11)};
    endfunction

    function automatic logic [7:0] exp_read(input logic [7:0] a, input logic dis,
                                            input logic [7:0] pa, input logic [7:0] pb,
                                            input logic [1:0] m);
        if (a == 8'hF2) return {6'b0, m};
        if (!dis && (a == 8'hC0 || a == 8'hDC)) return pa;
        if (!dis && (a == 8'hC1 || a == 8'hDD)) return pb;
        return 8'hFF;
    endfunction

    // One write cycle; strobes checked after the capturing edge and one edge later.
    task automatic do_write(input logic [7:0] a, input logic [7:0] d, input logic we);
        @(negedge clk);
        io_wr = we; io_addr = a; io_wdata = d;
        @(negedge clk);
        io_wr = 1'b0;
        if (we && a == 8'hF2) exp_mode = d[1:0];
        check(a == 8'hF0 ? "R2 addr strobe" : "R1 addr strobe decode",
              {15'b0, fm_addr_wr}, {15'b0, we && a == 8'hF0});
        check(a == 8'hF1 ? "R3 data strobe" : "R1 data strobe decode",
              {15'b0, fm_data_wr}, {15'b0, we && a == 8'hF1});
        if (we && (a == 8'hF0 || a == 8'hF1))
            check("R2 R3 strobe data", {8'b0, fm_wdata}, {8'b0, d});
        check(we ? "R4 enables" : "R9 enables held", {14'b0, psg_en, fm_en}, {14'b0, enables_of(exp_mode)});
        @(negedge clk);
        check("R2 R3 single pulse", {14'b0, fm_addr_wr, fm_data_wr}, 16'h0);
        io_addr = 8'hF2;
        #1;
        check(we ? "R1 mode readback" : "R9 mode readback", {8'b0, rd_data}, {14'b0, exp_mode});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R5 reset enables", {14'b0, psg_en, fm_en}, 16'b10);
        check("R5 reset strobes", {14'b0, fm_addr_wr, fm_data_wr}, 16'h0);
        io_addr = 8'hF2; #1;
        check("R5 reset readback", {8'b0, rd_data}, 16'h0);

        // R4 R6: every mode with noisy upper bits
        for (int m = 0; m < 4; m++) begin
            do_write(8'hF2, 8'hB4 | 8'(m), 1'b1);
            io_addr = 8'hF2; #1;
            check("R6 ctrl readback", {8'b0, rd_data}, {14'b0, 2'(m)});
        end

        // R9: writes with io_wr low to the live addresses
        do_write(8'hF2, 8'h02, 1'b0);
        do_write(8'hF0, 8'h11, 1'b0);
        do_write(8'hF1, 8'h22, 1'b0);
        do_write(8'hF2, 8'h01, 1'b1);
        do_write(8'hF2, 8'h00, 1'b0);

        // R1 R2 R3: full write sweep
        for (int a = 0; a < 256; a++)
            do_write(8'(a), 8'(a) ^ 8'h5A, 1'b1);

        // R6 R7 R8: full read sweep with both gate states
        do_write(8'hF2, 8'hFD, 1'b1);
        for (int dis = 0; dis < 2; dis++) begin
            for (int a = 0; a < 256; a++) begin
                @(negedge clk);
                io_disable  = dis[0];
                io_addr     = 8'(a);
                port_a_data = 8'(a) ^ 8'h96;
                port_b_data = ~8'(a);
                #1;
                check((a == 8'hF2) ? "R6 read" :
                      ((a[7:1] == 7'h60 || a[7:1] == 7'h6E) ? "R7 pad read" : "R8 open bus"),
                      {8'b0, rd_data},
                      {8'b0, exp_read(8'(a), dis[0], 8'(a) ^ 8'h96, ~8'(a), exp_mode)});
            end
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule